// File: doc/BRIEF.md
# Receive Frame Filter with Error Tallies

This block is the bit-level receive front end of a CSMA/CD station. It watches a decoded serial stream qualified by a bit strobe and a carrier indication. It hunts for the start-of-frame delimiter and drops everything in front of it. It then packs the bits into bytes, least significant bit first. The six destination-address bytes are held back until the address is known. At that point the frame is either passed on or silently dropped. The destination address is compared against the station's own address and the all-ones broadcast address. When enabled, it is also compared against any group address. A promiscuous switch accepts every frame.

Every accepted frame ends with a one-cycle completion pulse. The pulse carries three flags: frame-check failure, alignment failure, and lost because the downstream sink had no room. Three saturating counters tally these events for network-health monitoring. A host pulse clears all three counters.

The control is a single state machine:

- `ST_IDLE` waits for carrier.
- `ST_HUNT` searches for the delimiter.
- `ST_ADDR` collects the address bytes.
- `ST_FLUSH` decides on the address and releases the held bytes, one per cycle.
- `ST_PASS` forwards each new byte as it completes.
- `ST_DROP` discards the rest of a rejected frame.
- `ST_DONE` issues the completion pulse and updates the counters.

The transitions are:

- IDLE→HUNT when carrier rises.
- HUNT→ADDR when the delimiter is seen.
- HUNT→IDLE and ADDR→IDLE when carrier is lost.
- ADDR→FLUSH when the sixth address byte completes.
- FLUSH→DROP when the address is rejected.
- FLUSH→PASS when the last held byte is out and carrier is still present.
- FLUSH→DONE when the last held byte is out and carrier has ended.
- PASS→DONE when carrier falls.
- DROP→IDLE when carrier falls.
- DONE→IDLE unconditionally.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, `out_valid`, `frame_done`, all three status flags and all three tallies are 0.
- R2: A frame starts at the first bit after the arrival-order bit sequence 1,0,1,0,1,0,1,1 is seen while carrier is high. The search history is cleared in IDLE, so any preamble length works (even none). No bit before the delimiter is ever delivered.
- R3: Frame bits are packed first-received into bit 0 of each byte. Every complete byte of an accepted frame is delivered in order, including the four check bytes. Trailing bits that do not fill a byte are not delivered.
- R4: A frame is accepted in three cases: the destination equals `station_addr`, the destination is all ones, or `mcast_all` is 1 and the destination's first received bit is 1. The first received address byte sits in `station_addr[7:0]`. A frame that is not accepted produces no byte and no `frame_done`.
- R5: With `promisc` = 1, every frame is accepted whatever its destination.
- R6: The check runs a reflected CRC-32 over all frame bits: polynomial 0xEDB88320, register preset to all ones, and feedback equal to register bit 0 XOR the input bit. A good frame leaves 0xDEBB20E3 in the register, which is 0xC704DD7B bit-reversed. On a mismatch with a whole number of bytes, `done_crc_err` is 1.
- R7: On a mismatch with a bit count that is not a multiple of 8, `done_align_err` is 1 and `done_crc_err` is 0.
- R8: If `space_ok` is 0 when a byte is due, that byte and all later bytes of the frame are withheld. The completion pulse then carries `done_lost` = 1.
- R9: Each completion increments exactly one matching tally. A lost frame counts only in `tally_lost`. Otherwise a CRC error counts in `tally_crc` and an alignment error counts in `tally_align`. The tally update is visible in the same cycle as `frame_done`.
- R10: Tallies stop at their all-ones value. A one-cycle `tally_clr` sets all three to 0, and the clear wins over a simultaneous increment.
- R11: If carrier falls before the sixth address byte completes, nothing is delivered and no `frame_done` is issued.
- R12: `frame_done` is a single-cycle pulse that follows the frame's last delivered byte. It never shares a cycle with `out_valid`, and the status flags are 0 outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Carrier present; the frame ends when it falls |
| bit_stb | input | 1 | One-cycle strobe qualifying `bit_in` |
| bit_in | input | 1 | Decoded serial data bit |
| station_addr | input | 8*ADDR_BYTES (48) | Station address; first received byte in [7:0] |
| promisc | input | 1 | Accept every frame |
| mcast_all | input | 1 | Accept every group address |
| space_ok | input | 1 | Downstream sink can take a byte |
| tally_clr | input | 1 | Clear all tallies |
| out_valid | output | 1 | Byte on `out_data` is valid this cycle |
| out_data | output | 8 | Delivered frame byte |
| frame_done | output | 1 | Completion pulse for an accepted frame |
| done_crc_err | output | 1 | Check failure on a byte-aligned frame |
| done_align_err | output | 1 | Check failure on a non-byte-aligned frame |
| done_lost | output | 1 | Frame bytes were withheld for lack of space |
| tally_crc | output | TALLY_W (16) | CRC error tally |
| tally_align | output | TALLY_W (16) | Alignment error tally |
| tally_lost | output | TALLY_W (16) | Lost frame tally |

## Verification
The assertions check the following on every cycle:

- the counters never wrap, and never move by more than one between clears;
- a clear forces them to zero;
- the CRC and alignment flags are mutually exclusive, and no flag appears outside a completion pulse;
- a completion never coincides with a delivered byte;
- a lost or CRC-error completion advances its counter in step.

The bench scenarios show the rest:

- whether the delimiter is found after long and short preambles;
- whether the byte order and content are right at slow and back-to-back strobes;
- which destinations pass the filter under each mode;
- whether runt frames vanish;
- whether corrupted, dribbling and starved frames carry the right flags and counts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ADDR,
        ST_FLUSH,
        ST_PASS,
        ST_DROP,
        ST_DONE
    } rxf_state_t;

    localparam int          CRC_W            = 32;
    localparam logic [7:0]  SFD_PATTERN      = 8'b1010_1011;
    localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB8_8320;
    localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB_20E3;

    localparam int TALLY_CRC_IX   = 0;
    localparam int TALLY_ALIGN_IX = 1;
    localparam int TALLY_LOST_IX  = 2;
    localparam int N_TALLY        = 3;

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic bit_en,
    input  logic bit_in,
    output logic crc_ok
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;
    logic             fb;

    always_comb begin
        fb     = crc_q[0] ^ bit_in;
        crc_nx = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? CRC_POLY_REFL : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init) begin
            crc_q <= '1;
        end else if (bit_en) begin
            crc_q <= crc_nx;
        end
    end

    assign crc_ok = (crc_q == CRC_GOOD_RESIDUE);

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] station,
    input  logic              promisc,
    input  logic              mcast_all,
    output logic              accept
);

    logic hit_own;
    logic hit_bcast;
    logic hit_group;

    always_comb begin
        hit_own   = (dest == station);
        hit_bcast = &dest;
        hit_group = mcast_all & dest[0];
        accept    = promisc | hit_own | hit_bcast | hit_group;
    end

endmodule

// File: rtl/rxf_tally.sv
module rxf_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int TALLY_W    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    carrier,
    input  logic                    bit_stb,
    input  logic                    bit_in,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    promisc,
    input  logic                    mcast_all,
    input  logic                    space_ok,
    input  logic                    tally_clr,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    output logic                    frame_done,
    output logic                    done_crc_err,
    output logic                    done_align_err,
    output logic                    done_lost,
    output logic [TALLY_W-1:0]      tally_crc,
    output logic [TALLY_W-1:0]      tally_align,
    output logic [TALLY_W-1:0]      tally_lost
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    rxf_state_t cs;
    rxf_state_t ns;

    logic              bit_take;
    logic              in_frame;
    logic              fb_take;
    logic              sfd_seen;
    logic              byte_rdy;
    logic              emit_due;
    logic              accept;
    logic              crc_ok;
    logic              frame_bad;
    logic              aligned;
    logic [6:0]        hist;
    logic [2:0]        bit_phase;
    logic [7:0]        sr;
    logic [7:0]        byte_val;
    logic [7:0]        addr_q [ADDR_BYTES];
    logic [IDX_W-1:0]  addr_idx;
    logic [IDX_W-1:0]  flush_idx;
    logic [ADDR_W-1:0] dest_flat;
    logic              end_pend;
    logic              lost_q;

    logic [N_TALLY-1:0] tally_inc;
    logic [TALLY_W-1:0] tally_cnt [N_TALLY];

    // ---------------- bit qualification ----------------
    assign bit_take  = bit_stb & carrier;
    assign in_frame  = (cs == ST_ADDR) || (cs == ST_FLUSH) || (cs == ST_PASS);
    assign fb_take   = bit_take & in_frame;
    assign sfd_seen  = (cs == ST_HUNT) && bit_take && ({hist, bit_in} == SFD_PATTERN);
    assign byte_val  = {bit_in, sr[7:1]};
    assign byte_rdy  = fb_take && (bit_phase == 3'd7);
    assign emit_due  = ((cs == ST_FLUSH) && accept) || ((cs == ST_PASS) && byte_rdy);
    assign aligned   = (bit_phase == 3'd0);
    assign frame_bad = !crc_ok;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs <= ST_IDLE;
        end else begin
            cs <= ns;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        ns = cs;
        unique case (cs)
            ST_IDLE: begin
                if (carrier) ns = ST_HUNT;
            end
            ST_HUNT: begin
                if (!carrier)     ns = ST_IDLE;
                else if (sfd_seen) ns = ST_ADDR;
            end
            ST_ADDR: begin
                if (!carrier)                              ns = ST_IDLE;
                else if (byte_rdy && (addr_idx == LAST_IDX)) ns = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (!accept)                   ns = ST_DROP;
                else if (flush_idx == LAST_IDX) ns = (end_pend || !carrier) ? ST_DONE : ST_PASS;
            end
            ST_PASS: begin
                if (!carrier) ns = ST_DONE;
            end
            ST_DROP: begin
                if (!carrier) ns = ST_IDLE;
            end
            ST_DONE: begin
                ns = ST_IDLE;
            end
            default: ns = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist      <= '0;
            bit_phase <= '0;
            sr        <= '0;
            addr_idx  <= '0;
            flush_idx <= '0;
            end_pend  <= 1'b0;
            lost_q    <= 1'b0;
            for (int i = 0; i < ADDR_BYTES; i++) addr_q[i] <= '0;
        end else begin
            if (cs == ST_IDLE) begin
                hist <= '0;
            end else if ((cs == ST_HUNT) && bit_take) begin
                hist <= {hist[5:0], bit_in};
            end

            if (sfd_seen) begin
                bit_phase <= '0;
                addr_idx  <= '0;
                flush_idx <= '0;
                end_pend  <= 1'b0;
                lost_q    <= 1'b0;
            end else begin
                if (fb_take) begin
                    bit_phase <= bit_phase + 3'd1;
                    sr        <= byte_val;
                end
                if ((cs == ST_ADDR) && byte_rdy) begin
                    addr_q[addr_idx] <= byte_val;
                    addr_idx         <= addr_idx + 1'b1;
                end
                if (cs == ST_FLUSH) begin
                    flush_idx <= flush_idx + 1'b1;
                    if (!carrier) end_pend <= 1'b1;
                end
                if (emit_due && !space_ok) begin
                    lost_q <= 1'b1;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_data       <= '0;
            frame_done     <= 1'b0;
            done_crc_err   <= 1'b0;
            done_align_err <= 1'b0;
            done_lost      <= 1'b0;
        end else begin
            out_valid      <= emit_due && !lost_q && space_ok;
            out_data       <= (cs == ST_FLUSH) ? addr_q[flush_idx] : byte_val;
            frame_done     <= (cs == ST_DONE);
            done_crc_err   <= (cs == ST_DONE) && frame_bad && aligned;
            done_align_err <= (cs == ST_DONE) && frame_bad && !aligned;
            done_lost      <= (cs == ST_DONE) && lost_q;
        end
    end

    // ---------------- sub-blocks ----------------
    rxf_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (sfd_seen),
        .bit_en (fb_take),
        .bit_in (bit_in),
        .crc_ok (crc_ok)
    );

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_dest
        assign dest_flat[8*g +: 8] = addr_q[g];
    end

    rxf_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .dest      (dest_flat),
        .station   (station_addr),
        .promisc   (promisc),
        .mcast_all (mcast_all),
        .accept    (accept)
    );

    assign tally_inc[TALLY_CRC_IX]   = (cs == ST_DONE) && frame_bad && aligned && !lost_q;
    assign tally_inc[TALLY_ALIGN_IX] = (cs == ST_DONE) && frame_bad && !aligned && !lost_q;
    assign tally_inc[TALLY_LOST_IX]  = (cs == ST_DONE) && lost_q;

    for (genvar t = 0; t < N_TALLY; t++) begin : g_tally
        rxf_tally #(.W(TALLY_W)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (tally_clr),
            .inc   (tally_inc[t]),
            .cnt   (tally_cnt[t])
        );
    end

    assign tally_crc   = tally_cnt[TALLY_CRC_IX];
    assign tally_align = tally_cnt[TALLY_ALIGN_IX];
    assign tally_lost  = tally_cnt[TALLY_LOST_IX];

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int TALLY_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tally_clr,
    input logic               out_valid,
    input logic               frame_done,
    input logic               done_crc_err,
    input logic               done_align_err,
    input logic               done_lost,
    input logic [TALLY_W-1:0] tally_crc,
    input logic [TALLY_W-1:0] tally_align,
    input logic [TALLY_W-1:0] tally_lost
);

    localparam logic [TALLY_W-1:0] TOP = '1;

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tally_clr |=> (tally_crc == '0) && (tally_align == '0) && (tally_lost == '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tally_clr |=> (tally_crc >= $past(tally_crc)) && (tally_align >= $past(tally_align))
                       && (tally_lost >= $past(tally_lost)));

    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tally_clr |=> ((tally_crc == $past(tally_crc)) || (tally_crc == $past(tally_crc) + 1'b1))
                    && ((tally_align == $past(tally_align)) || (tally_align == $past(tally_align) + 1'b1))
                    && ((tally_lost == $past(tally_lost)) || (tally_lost == $past(tally_lost) + 1'b1)));

    p_lost_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && done_lost && !$past(tally_clr) && ($past(tally_lost) != TOP))
        |-> (tally_lost == $past(tally_lost) + 1'b1));

    p_crc_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && done_crc_err && !done_lost && !$past(tally_clr) && ($past(tally_crc) != TOP))
        |-> (tally_crc == $past(tally_crc) + 1'b1));

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !(done_crc_err && done_align_err));

    p_flags_in_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_crc_err || done_align_err || done_lost) |-> frame_done);

    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && frame_done));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind rx_frame_filter rxf_checker #(.TALLY_W(TALLY_W)) u_rxf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tally_clr      (tally_clr),
    .out_valid      (out_valid),
    .frame_done     (frame_done),
    .done_crc_err   (done_crc_err),
    .done_align_err (done_align_err),
    .done_lost      (done_lost),
    .tally_crc      (tally_crc),
    .tally_align    (tally_align),
    .tally_lost     (tally_lost)
);

// File: tb/tb_rx_frame_filter.sv
`timescale 1ns/1ps
module tb_rx_frame_filter;

    localparam int TW = 3;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          carrier = 1'b0;
    logic          bit_stb = 1'b0;
    logic          bit_in = 1'b0;
    logic [47:0]   station_addr = 48'h6655_4433_2211;
    logic          promisc = 1'b0;
    logic          mcast_all = 1'b0;
    logic          space_ok = 1'b1;
    logic          tally_clr = 1'b0;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          frame_done;
    logic          done_crc_err;
    logic          done_align_err;
    logic          done_lost;
    logic [TW-1:0] tally_crc;
    logic [TW-1:0] tally_align;
    logic [TW-1:0] tally_lost;

    always #2.5 clk = ~clk;

    rx_frame_filter #(.TALLY_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .carrier(carrier), .bit_stb(bit_stb), .bit_in(bit_in),
        .station_addr(station_addr), .promisc(promisc), .mcast_all(mcast_all),
        .space_ok(space_ok), .tally_clr(tally_clr), .out_valid(out_valid), .out_data(out_data),
        .frame_done(frame_done), .done_crc_err(done_crc_err), .done_align_err(done_align_err),
        .done_lost(done_lost), .tally_crc(tally_crc), .tally_align(tally_align),
        .tally_lost(tally_lost)
    );

    int n_check = 0;
    int n_fail  = 0;
    int m_crc = 0, m_align = 0, m_lost = 0;

    logic [7:0] exp_bytes[$];
    string      byte_tag[$];
    logic [2:0] exp_stat[$];
    string      stat_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_check++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_bit = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
    endfunction

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) r = crc_bit(r, d[k]);
        crc_byte = r;
    endfunction

    function automatic bit accepts(input logic [47:0] d);
        accepts = promisc || (d == station_addr) || (&d) || (mcast_all && d[0]);
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_bytes.size() == 0) begin
                    check(1'b0, "R4", "unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_bytes.pop_front();
                    t = byte_tag.pop_front();
                    check(out_data == e, t, "byte", out_data, e);
                end
            end
            if (frame_done) begin
                check(exp_bytes.size() == 0, "R12", "done before last byte", exp_bytes.size(), 0);
                if (exp_stat.size() == 0) begin
                    check(1'b0, "R4", "unexpected frame_done", 1, 0);
                end else begin
                    logic [2:0] s;
                    string t;
                    s = exp_stat.pop_front();
                    t = stat_tag.pop_front();
                    check({done_lost, done_align_err, done_crc_err} == s, t, "status {lost,align,crc}",
                          {done_lost, done_align_err, done_crc_err}, s);
                end
            end
        end
    end

    task automatic put_bit(input logic b, input int gap);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_in  = b;
        repeat (gap) begin
            @(negedge clk);
            bit_stb = 1'b0;
        end
    endtask

    task automatic send_raw(input logic [7:0] fr[$], input int extra, input int pre, input int gap);
        @(negedge clk);
        carrier = 1'b1;
        for (int i = 0; i < pre; i++) put_bit((i % 2) == 0, gap);
        for (int i = 7; i >= 0; i--) put_bit(1'(8'b1010_1011 >> i), gap);
        foreach (fr[i]) for (int k = 0; k < 8; k++) put_bit(fr[i][k], gap);
        for (int i = 0; i < extra; i++) put_bit(1'b1, gap);
        @(negedge clk);
        bit_stb = 1'b0;
        carrier = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic check_tallies(input string tag);
        check(tally_crc == TW'(m_crc), tag, "tally_crc", tally_crc, m_crc);
        check(tally_align == TW'(m_align), tag, "tally_align", tally_align, m_align);
        check(tally_lost == TW'(m_lost), tag, "tally_lost", tally_lost, m_lost);
    endtask

    task automatic drive_frame(input logic [47:0] dst, input int plen, input int seed,
                               input bit corrupt, input int extra, input int pre, input int gap,
                               input bit no_space, input string tag);
        logic [7:0]  fr[$];
        logic [31:0] c;
        logic [31:0] r;
        bit          bad, al, acc;
        for (int i = 0; i < 6; i++) fr.push_back(dst[8*i +: 8]);
        for (int i = 0; i < 6; i++) fr.push_back(8'h02 + 8'(i));
        fr.push_back(8'h08);
        fr.push_back(8'h00);
        for (int i = 0; i < plen; i++) fr.push_back(8'(seed + i * 7));
        c = 32'hFFFF_FFFF;
        foreach (fr[i]) c = crc_byte(c, fr[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) fr.push_back(c[8*i +: 8]);
        if (corrupt) fr[14] = fr[14] ^ 8'h10;
        r = 32'hFFFF_FFFF;
        foreach (fr[i]) r = crc_byte(r, fr[i]);
        for (int i = 0; i < extra; i++) r = crc_bit(r, 1'b1);
        bad = (r != 32'hDEBB_20E3);
        al  = (extra % 8) == 0;
        acc = accepts(dst);
        if (acc) begin
            if (!no_space) begin
                foreach (fr[i]) begin
                    exp_bytes.push_back(fr[i]);
                    byte_tag.push_back(tag);
                end
            end
            exp_stat.push_back({no_space, bad && !al, bad && al});
            stat_tag.push_back(tag);
            if (no_space)       m_lost  = (m_lost  < TMAX) ? m_lost  + 1 : m_lost;
            else if (bad && al) m_crc   = (m_crc   < TMAX) ? m_crc   + 1 : m_crc;
            else if (bad)       m_align = (m_align < TMAX) ? m_align + 1 : m_align;
        end
        space_ok = !no_space;
        send_raw(fr, extra, pre, gap);
        space_ok = 1'b1;
        check(exp_bytes.size() == 0, tag, "bytes not delivered", exp_bytes.size(), 0);
        check(exp_stat.size() == 0, tag, "completion missing", exp_stat.size(), 0);
        exp_bytes.delete();
        byte_tag.delete();
        exp_stat.delete();
        stat_tag.delete();
        check_tallies({tag, " R9"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_check++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_check, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] runt[$];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0, "R1", "out_valid", out_valid, 0);
        check(frame_done == 0, "R1", "frame_done", frame_done, 0);
        check({done_crc_err, done_align_err, done_lost} == 0, "R1", "flags",
              {done_crc_err, done_align_err, done_lost}, 0);
        check_tallies("R1");

        // R2/R3/R6 own address, long preamble, then short preamble, then none
        drive_frame(48'h6655_4433_2211, 20, 3, 0, 0, 56, 1, 0, "R2 R3 R6 long preamble");
        drive_frame(48'h6655_4433_2211, 20, 9, 0, 0, 2, 1, 0, "R2 short preamble");
        drive_frame(48'h6655_4433_2211, 12, 5, 0, 0, 0, 1, 0, "R2 no preamble");
        // R3 back-to-back strobes
        drive_frame(48'h6655_4433_2211, 24, 17, 0, 0, 16, 0, 0, "R3 fast strobe");
        // R4 filtering
        drive_frame(48'h0000_0000_00AA, 20, 1, 0, 0, 16, 1, 0, "R4 other unicast rejected");
        drive_frame(48'hFFFF_FFFF_FFFF, 20, 2, 0, 0, 16, 1, 0, "R4 broadcast");
        drive_frame(48'h0000_5E00_0001, 20, 4, 0, 0, 16, 1, 0, "R4 group rejected");
        mcast_all = 1'b1;
        drive_frame(48'h0000_5E00_0001, 20, 6, 0, 0, 16, 1, 0, "R4 group accepted");
        mcast_all = 1'b0;
        // R5 promiscuous
        promisc = 1'b1;
        drive_frame(48'h1234_5678_9A10, 20, 8, 0, 0, 16, 1, 0, "R5 promiscuous");
        promisc = 1'b0;
        // R6 CRC error
        drive_frame(48'h6655_4433_2211, 20, 11, 1, 0, 16, 1, 0, "R6 crc error");
        // R7 alignment error
        drive_frame(48'h6655_4433_2211, 20, 13, 0, 3, 16, 1, 0, "R7 dribble bits");
        // R8 lost frame
        drive_frame(48'h6655_4433_2211, 20, 15, 0, 0, 16, 1, 1, "R8 no space");
        // R11 runt
        runt.push_back(8'h11);
        runt.push_back(8'h22);
        runt.push_back(8'h33);
        send_raw(runt, 0, 16, 1);
        check(exp_stat.size() == 0, "R11", "runt queue", exp_stat.size(), 0);
        check_tallies("R11");
        // R10 saturation then clear
        for (int i = 0; i < 9; i++)
            drive_frame(48'h6655_4433_2211, 4, 20 + i, 1, 0, 8, 1, 0, "R10 saturate");
        check(tally_crc == TW'(TMAX), "R10", "tally_crc saturated", tally_crc, TMAX);
        @(negedge clk);
        tally_clr = 1'b1;
        @(negedge clk);
        tally_clr = 1'b0;
        m_crc = 0;
        m_align = 0;
        m_lost = 0;
        @(negedge clk);
        check_tallies("R10 clear");
        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_check, n_fail);
        $finish;
    end

endmodule